// File: doc/BRIEF.md
# Command Code and Page Mode Controller

This block sits behind a two-wire serial slave front end. After the slave address has been matched with a write direction, the front end hands over the first byte and says so with a one-cycle strobe. The block decides whether that byte is a register pointer or a special command. It answers with an acknowledge or reject decision one cycle later. It commits the effect only when the front end reaches the acknowledge bit. If a STOP condition arrives first, the byte is dropped.

Three nested address spaces are tracked. The default register page holds pointers 000h–0FFh. The configuration flash page holds 200h–28Fh. The user flash page holds 300h–3A4h and 3ADh–3FFh. Eight command codes, A5h through ACh, move between the pages, announce a block write or block read, request a software reboot, or request an emergency fault save. The reboot and save requests leave the block as one-cycle pulses. The pointer is presented as a 10-bit address for the read or write that follows.

Top module: `pmc_top`

## Requirements
- R1: After reset, page_o is 0 (default page), ptr_o is 000h, resp_vld_o, blk_wr_o, blk_rd_o, reboot_o and save_o are all 0.
- R2: One cycle after byte_vld_i, resp_vld_o is 1 and resp_ack_o gives the accept (1) or reject (0) decision for that byte in the current page. The decision then holds until the acknowledge slot or a STOP.
- R3: In the default page (page_o = 0), any byte outside A5h–ACh is accepted. On the acknowledge slot, ptr_o becomes {2'b00, byte}.
- R4: In the flash page (page_o = 1), bytes 00h–8Fh are accepted and set ptr_o to 200h + byte. Non-command bytes 90h–FFh are rejected.
- R5: In the user flash page (page_o = 2), any byte outside A5h–ACh is accepted and sets ptr_o to 300h + byte.
- R6: A5h and A6h are accepted in every page and leave ptr_o unchanged. A5h sets blk_wr_o and A6h sets blk_rd_o, and at most one of the two is high at a time. Either flag is cleared by stop_i or by any later committed byte.
- R7: A7h is accepted in every page. On commit, reboot_o is high for exactly one cycle, page_o returns to 0 and ptr_o to 000h.
- R8: A8h is accepted in every page. On commit, save_o is high for exactly one cycle, and page_o and ptr_o are unchanged.
- R9: A9h is accepted only in the default page and moves to the flash page. AAh is accepted only in the flash page and moves to the default page.
- R10: ABh is accepted only in the flash page and moves to the user page. ACh is accepted only in the user page and moves to the flash page. Anywhere else these codes are rejected and page_o is unchanged, so the user page is reached only from the flash page.
- R11: A stop_i while a decision is pending discards the byte. ptr_o, page_o, reboot_o and save_o are unaffected, and resp_vld_o falls in the next cycle.
- R12: A rejected byte that reaches the acknowledge slot changes neither ptr_o nor page_o and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| byte_i | input | 8 | First byte after a write-addressed slave match |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i is valid |
| ack_slot_i | input | 1 | One-cycle strobe: the acknowledge bit is being driven now |
| stop_i | input | 1 | One-cycle strobe: STOP condition seen on the bus |
| resp_vld_o | output | 1 | A byte decision is pending |
| resp_ack_o | output | 1 | Pending decision: 1 accept, 0 reject |
| ptr_o | output | 10 | Current register/flash pointer |
| page_o | output | 2 | Active page: 0 default, 1 flash, 2 user flash |
| blk_wr_o | output | 1 | Block write announced |
| blk_rd_o | output | 1 | Block read announced |
| reboot_o | output | 1 | One-cycle software reboot request |
| save_o | output | 1 | One-cycle emergency fault save request |

## Verification
The bench walks the page ladder both ways. At every rung it sends the mode codes that are illegal there: A9h inside flash, ABh and ACh from default, and AAh from user. A controller that ignored page legality would either leap from default straight into user flash or accept an exit it should reject. The bench also probes the edge of the flash range at 8Fh and 90h, where an off-by-one would accept 290h. It sends a STOP between the decision and the acknowledge, which a careless design would still commit. Finally, it checks that the reboot and save requests last exactly one cycle, and that a reboot from the user page lands back in the default page with a zero pointer.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int PMC_PTR_W = 10;
    localparam int PMC_BYTE_W = 8;

    typedef enum logic [1:0] {
        PG_DEFAULT = 2'd0,
        PG_FLASH   = 2'd1,
        PG_USER    = 2'd2
    } page_e;

    typedef enum logic [2:0] {
        OP_POINTER = 3'd0,
        OP_BLK_WR  = 3'd1,
        OP_BLK_RD  = 3'd2,
        OP_REBOOT  = 3'd3,
        OP_SAVE    = 3'd4,
        OP_MOVE    = 3'd5
    } op_e;

    typedef struct packed {
        logic                 legal;
        op_e                  op;
        page_e                dest;
        logic [PMC_PTR_W-1:0] ptr;
    } dec_t;

    typedef struct packed {
        logic                 pend;
        dec_t                 pdec;
        page_e                page;
        logic [PMC_PTR_W-1:0] ptr;
        logic                 blk_wr;
        logic                 blk_rd;
        logic                 reboot;
        logic                 save;
    } ctrl_st_t;

endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
    import pmc_pkg::*;
#(
    parameter logic [PMC_BYTE_W-1:0] CMD_FIRST  = 8'hA5,
    parameter logic [PMC_PTR_W-1:0]  FLASH_BASE = 10'h200,
    parameter logic [PMC_BYTE_W-1:0] FLASH_LAST = 8'h8F,
    parameter logic [PMC_PTR_W-1:0]  USER_BASE  = 10'h300
) (
    input  logic [PMC_BYTE_W-1:0] byte_i,
    input  page_e                 page_i,
    output dec_t                  dec_o
);

    localparam int CMD_COUNT = 8;
    localparam logic [PMC_BYTE_W-1:0] CMD_LAST = CMD_FIRST + PMC_BYTE_W'(CMD_COUNT - 1);
    localparam int PAD_W = PMC_PTR_W - PMC_BYTE_W;

    logic                  is_cmd;
    logic [PMC_BYTE_W-1:0] cmd_ofs;
    logic [PMC_PTR_W-1:0]  byte_wide;

    assign is_cmd    = (byte_i >= CMD_FIRST) && (byte_i <= CMD_LAST);
    assign cmd_ofs   = byte_i - CMD_FIRST;
    assign byte_wide = {{PAD_W{1'b0}}, byte_i};

    always_comb begin
        dec_o       = '0;
        dec_o.op    = OP_POINTER;
        dec_o.dest  = page_i;
        dec_o.ptr   = '0;
        dec_o.legal = 1'b0;
        if (is_cmd) begin
            unique case (cmd_ofs[2:0])
                3'd0: begin dec_o.op = OP_BLK_WR; dec_o.legal = 1'b1; end
                3'd1: begin dec_o.op = OP_BLK_RD; dec_o.legal = 1'b1; end
                3'd2: begin dec_o.op = OP_REBOOT; dec_o.legal = 1'b1; end
                3'd3: begin dec_o.op = OP_SAVE;   dec_o.legal = 1'b1; end
                3'd4: begin
                    dec_o.op    = OP_MOVE;
                    dec_o.dest  = PG_FLASH;
                    dec_o.legal = (page_i == PG_DEFAULT);
                end
                3'd5: begin
                    dec_o.op    = OP_MOVE;
                    dec_o.dest  = PG_DEFAULT;
                    dec_o.legal = (page_i == PG_FLASH);
                end
                3'd6: begin
                    dec_o.op    = OP_MOVE;
                    dec_o.dest  = PG_USER;
                    dec_o.legal = (page_i == PG_FLASH);
                end
                default: begin
                    dec_o.op    = OP_MOVE;
                    dec_o.dest  = PG_FLASH;
                    dec_o.legal = (page_i == PG_USER);
                end
            endcase
        end else begin
            unique case (page_i)
                PG_FLASH: begin
                    dec_o.legal = (byte_i <= FLASH_LAST);
                    dec_o.ptr   = FLASH_BASE + byte_wide;
                end
                PG_USER: begin
                    dec_o.legal = 1'b1;
                    dec_o.ptr   = USER_BASE + byte_wide;
                end
                default: begin
                    dec_o.legal = 1'b1;
                    dec_o.ptr   = byte_wide;
                end
            endcase
        end
    end

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 byte_vld_i,
    input  logic                 ack_slot_i,
    input  logic                 stop_i,
    input  dec_t                 dec_i,
    output page_e                page_o,
    output logic                 resp_vld_o,
    output logic                 resp_ack_o,
    output logic [PMC_PTR_W-1:0] ptr_o,
    output logic                 blk_wr_o,
    output logic                 blk_rd_o,
    output logic                 reboot_o,
    output logic                 save_o
);

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.reboot = 1'b0;
        st_d.save   = 1'b0;
        if (stop_i) begin
            st_d.blk_wr = 1'b0;
            st_d.blk_rd = 1'b0;
        end
        if (byte_vld_i) begin
            st_d.pend = 1'b1;
            st_d.pdec = dec_i;
        end else if (st_q.pend && stop_i) begin
            st_d.pend = 1'b0;
        end else if (st_q.pend && ack_slot_i) begin
            st_d.pend = 1'b0;
            if (st_q.pdec.legal) begin
                st_d.blk_wr = 1'b0;
                st_d.blk_rd = 1'b0;
                unique case (st_q.pdec.op)
                    OP_POINTER: st_d.ptr    = st_q.pdec.ptr;
                    OP_BLK_WR:  st_d.blk_wr = 1'b1;
                    OP_BLK_RD:  st_d.blk_rd = 1'b1;
                    OP_REBOOT: begin
                        st_d.page   = PG_DEFAULT;
                        st_d.ptr    = '0;
                        st_d.reboot = 1'b1;
                    end
                    OP_SAVE:    st_d.save = 1'b1;
                    default:    st_d.page = st_q.pdec.dest;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.page <= PG_DEFAULT;
            st_q.pdec <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page_o     = st_q.page;
    assign resp_vld_o = st_q.pend;
    assign resp_ack_o = st_q.pend & st_q.pdec.legal;
    assign ptr_o      = st_q.ptr;
    assign blk_wr_o   = st_q.blk_wr;
    assign blk_rd_o   = st_q.blk_rd;
    assign reboot_o   = st_q.reboot;
    assign save_o     = st_q.save;

    p_decision_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_vld_i |=> (resp_vld_o && (resp_ack_o == $past(dec_i.legal))));

    p_blk_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(blk_wr_o && blk_rd_o));

    p_reboot_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reboot_o |=> !reboot_o);

    p_reboot_home_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reboot_o |-> (page_o == PG_DEFAULT && ptr_o == '0));

    p_save_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        save_o |=> !save_o);

    p_user_entry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (page_o == PG_USER && $past(page_o) != PG_USER) |-> $past(page_o) == PG_FLASH);

    p_stop_drops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_vld_o && stop_i && !byte_vld_i) |=>
            ($stable(ptr_o) && $stable(page_o) && !reboot_o && !save_o && !resp_vld_o));

    p_reject_inert_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_vld_o && !resp_ack_o && ack_slot_i && !stop_i && !byte_vld_i) |=>
            ($stable(ptr_o) && $stable(page_o) && !reboot_o && !save_o));

endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter logic [PMC_BYTE_W-1:0] CMD_FIRST  = 8'hA5,
    parameter logic [PMC_PTR_W-1:0]  FLASH_BASE = 10'h200,
    parameter logic [PMC_BYTE_W-1:0] FLASH_LAST = 8'h8F,
    parameter logic [PMC_PTR_W-1:0]  USER_BASE  = 10'h300
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PMC_BYTE_W-1:0] byte_i,
    input  logic                  byte_vld_i,
    input  logic                  ack_slot_i,
    input  logic                  stop_i,
    output logic                  resp_vld_o,
    output logic                  resp_ack_o,
    output logic [PMC_PTR_W-1:0]  ptr_o,
    output logic [1:0]            page_o,
    output logic                  blk_wr_o,
    output logic                  blk_rd_o,
    output logic                  reboot_o,
    output logic                  save_o
);

    dec_t  dec;
    page_e page;

    pmc_decode #(
        .CMD_FIRST (CMD_FIRST),
        .FLASH_BASE(FLASH_BASE),
        .FLASH_LAST(FLASH_LAST),
        .USER_BASE (USER_BASE)
    ) u_decode (
        .byte_i(byte_i),
        .page_i(page),
        .dec_o (dec)
    );

    pmc_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .byte_vld_i(byte_vld_i),
        .ack_slot_i(ack_slot_i),
        .stop_i    (stop_i),
        .dec_i     (dec),
        .page_o    (page),
        .resp_vld_o(resp_vld_o),
        .resp_ack_o(resp_ack_o),
        .ptr_o     (ptr_o),
        .blk_wr_o  (blk_wr_o),
        .blk_rd_o  (blk_rd_o),
        .reboot_o  (reboot_o),
        .save_o    (save_o)
    );

    assign page_o = page;

endmodule

// File: tb/pmc_top_tb_top.sv
module pmc_top_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_in = '0;
    logic       byte_vld = 1'b0;
    logic       ack_slot = 1'b0;
    logic       stop = 1'b0;
    logic       resp_vld, resp_ack, blk_wr, blk_rd, reboot, save;
    logic [9:0] ptr;
    logic [1:0] page;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .byte_vld_i(byte_vld),
        .ack_slot_i(ack_slot), .stop_i(stop), .resp_vld_o(resp_vld),
        .resp_ack_o(resp_ack), .ptr_o(ptr), .page_o(page), .blk_wr_o(blk_wr),
        .blk_rd_o(blk_rd), .reboot_o(reboot), .save_o(save)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present a byte, check the decision, then either acknowledge it or abort with STOP.
    task automatic put(logic [7:0] b, logic exp_ack, string req, bit abort = 1'b0);
        @(negedge clk);
        byte_in = b; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        chk({req, " resp_vld (R2)"}, resp_vld, 1);
        chk({req, " resp_ack (R2)"}, resp_ack, exp_ack);
        if (abort) stop = 1'b1; else ack_slot = 1'b1;
        @(negedge clk);
        stop = 1'b0; ack_slot = 1'b0;
        chk({req, " resp cleared"}, resp_vld, 0);
    endtask

    task automatic expect_state(string req, logic [1:0] pg, logic [9:0] p);
        chk({req, " page"}, page, pg);
        chk({req, " ptr"}, ptr, p);
    endtask

    task automatic t_reset_r1();
        chk("R1 page", page, 0);
        chk("R1 ptr", ptr, 0);
        chk("R1 resp_vld", resp_vld, 0);
        chk("R1 flags", {blk_wr, blk_rd, reboot, save}, 0);
    endtask

    task automatic t_default_ptr_r3();
        put(8'h3C, 1, "R3 3C");  expect_state("R3 3C", 0, 10'h03C);
        put(8'hFF, 1, "R3 FF");  expect_state("R3 FF", 0, 10'h0FF);
        put(8'hA4, 1, "R3 A4");  expect_state("R3 A4", 0, 10'h0A4);
    endtask

    task automatic t_bad_default_r10();
        put(8'hAB, 0, "R10 AB@def"); expect_state("R10 AB@def", 0, 10'h0A4);
        put(8'hAC, 0, "R10 AC@def"); expect_state("R10 AC@def", 0, 10'h0A4);
        put(8'hAA, 0, "R9 AA@def");  expect_state("R9 AA@def", 0, 10'h0A4);
    endtask

    task automatic t_flash_r4();
        put(8'hA9, 1, "R9 A9@def");  expect_state("R9 A9@def", 1, 10'h0A4);
        put(8'h10, 1, "R4 10");      expect_state("R4 10", 1, 10'h210);
        put(8'h8F, 1, "R4 8F");      expect_state("R4 8F", 1, 10'h28F);
        put(8'h90, 0, "R4 90");      expect_state("R12 90", 1, 10'h28F);
        put(8'hFF, 0, "R4 FF");      expect_state("R12 FF", 1, 10'h28F);
        put(8'hA9, 0, "R9 A9@fl");   expect_state("R9 A9@fl", 1, 10'h28F);
        put(8'hAC, 0, "R10 AC@fl");  expect_state("R10 AC@fl", 1, 10'h28F);
    endtask

    task automatic t_user_r5();
        put(8'hAB, 1, "R10 AB@fl");  expect_state("R10 AB@fl", 2, 10'h28F);
        put(8'h20, 1, "R5 20");      expect_state("R5 20", 2, 10'h320);
        put(8'hFF, 1, "R5 FF");      expect_state("R5 FF", 2, 10'h3FF);
        put(8'hAB, 0, "R10 AB@usr"); expect_state("R10 AB@usr", 2, 10'h3FF);
        put(8'hAA, 0, "R9 AA@usr");  expect_state("R9 AA@usr", 2, 10'h3FF);
        put(8'hA9, 0, "R9 A9@usr");  expect_state("R9 A9@usr", 2, 10'h3FF);
        put(8'hAC, 1, "R10 AC@usr"); expect_state("R10 AC@usr", 1, 10'h3FF);
        put(8'hAA, 1, "R9 AA@fl");   expect_state("R9 AA@fl", 0, 10'h3FF);
    endtask

    task automatic t_block_r6();
        put(8'h40, 1, "R6 setup");
        put(8'hA5, 1, "R6 A5");
        chk("R6 blk_wr", {blk_wr, blk_rd}, 2'b10);
        chk("R6 ptr kept", ptr, 10'h040);
        @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
        chk("R6 stop clears", {blk_wr, blk_rd}, 2'b00);
        put(8'hA6, 1, "R6 A6");
        chk("R6 blk_rd", {blk_wr, blk_rd}, 2'b01);
        put(8'hA5, 1, "R6 A5 after A6");
        chk("R6 exclusive", {blk_wr, blk_rd}, 2'b10);
        put(8'h41, 1, "R6 next byte");
        chk("R6 cleared by byte", {blk_wr, blk_rd}, 2'b00);
    endtask

    task automatic t_save_r8();
        put(8'hA9, 1, "R8 to flash");
        put(8'h05, 1, "R8 ptr");
        put(8'hA8, 1, "R8 A8");
        chk("R8 save pulse", save, 1);
        chk("R8 no reboot", reboot, 0);
        expect_state("R8 state", 1, 10'h205);
        @(negedge clk);
        chk("R8 save single", save, 0);
    endtask

    task automatic t_stop_r11();
        put(8'h55, 1, "R11 abort", 1'b1);
        expect_state("R11 kept", 1, 10'h205);
        put(8'hAA, 1, "R11 abort move", 1'b1);
        expect_state("R11 page kept", 1, 10'h205);
        put(8'hA7, 1, "R11 abort reboot", 1'b1);
        chk("R11 no reboot", reboot, 0);
        expect_state("R11 after reboot abort", 1, 10'h205);
    endtask

    task automatic t_reboot_r7();
        put(8'hAB, 1, "R7 to user");
        put(8'h33, 1, "R7 ptr");
        expect_state("R7 before", 2, 10'h333);
        put(8'hA7, 1, "R7 A7");
        chk("R7 reboot pulse", reboot, 1);
        expect_state("R7 home", 0, 10'h000);
        @(negedge clk);
        chk("R7 reboot single", reboot, 0);
        chk("R7 save quiet", save, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_default_ptr_r3();
        t_bad_default_r10();
        t_flash_r4();
        t_user_r5();
        t_block_r6();
        t_save_r8();
        t_stop_r11();
        t_reboot_r7();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule